// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the strobe and address timing of a microcontroller-style external memory bus. On this bus one 8-bit port carries the low address byte first and then data. A second 8-bit port carries the high address byte. The sequencer advances one position per oscillator-period enable tick. A machine cycle is 12 ticks: 6 states of 2 phases each. The cycle is split into two halves of 6 ticks, and every half is an opcode-fetch half, a data-address half or a data-transfer half.

Fetch halves take their address from `pc_addr`. The program-store read strobe pulses only when `code_ext` says the code comes from external memory. An external data access is accepted only on the tick that closes the first half of a machine cycle. It then takes the second half of that cycle, where the address latch strobe carries the data address. It also takes the first half of the following cycle, where the read or write strobe is active. That fixed pattern drops one address-latch pulse and two program-store pulses for every data access. The high port shows either the address high byte or a register value supplied from outside, chosen by the width of the data address.

Top module: `xbus_seq`

## Requirements
- R1: Outputs move only on ticks where `osc_en` is high. Positions within a half run 0..5, and two halves make a 12-tick machine cycle. Reset starts at position 0 of the first half.
- R2: `ale` is high at positions 2 and 3 of every fetch half and every data-address half. This gives two pulses per machine cycle during plain fetching, whether the code is internal or external.
- R3: In a fetch half latched with `code_ext`=1, `psen_n` is low at positions 4 and 5. It is never low in a fetch half latched with `code_ext`=0. `pc_addr` and `code_ext` are sampled on the tick that closes the previous half.
- R4: `data_req`, `data_addr`, `data_wr`, `data_wide` and `data_wdata` are sampled on the tick that closes position 5 of the first half. `data_taken` is high for one clock after that tick. The access then occupies the next half (address) and the half after it (transfer).
- R5: No `ale` pulse occurs in a transfer half. Over the two machine cycles holding one data access, `ale` pulses exactly 3 times.
- R6: `psen_n` stays high in both the address half and the transfer half. With external code, it pulses exactly twice over those two machine cycles.
- R7: At positions 0..3 of an external fetch half or of an address half, `ad_oe`=1 and `ad_out` carries the address low byte, all ones included.
- R8: `hi_port` carries the address high byte for external fetches and for 16-bit data accesses (`data_wide`=1). It carries `hi_reg` for 8-bit data accesses and for internal fetches.
- R9: In a read transfer half, `rd_n` is low for all 6 positions and `ad_oe`=0. `ad_in` is captured on the tick closing position 5: `rdata_valid` is high for one clock with `rdata_is_code`=0. An external fetch captures the same way at its position 5, with `rdata_is_code`=1.
- R10: A write (`data_wr`=1) drives `ad_out`=`data_wdata` with `ad_oe`=1 from position 4 of the address half through the end of the transfer half. In the transfer half `wr_n` is low and `rd_n` stays high.
- R11: After reset: `ale`=0, `psen_n`=1, `rd_n`=1, `wr_n`=1, `ad_oe`=0 and `ad_out`=8'hFF. The first half is an internal fetch.
- R12: Whenever the low port is not driven (`ad_oe`=0), `ad_out` reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-clock enable per oscillator period |
| code_ext | input | 1 | Next fetch half reads external program memory |
| pc_addr | input | 16 | Code fetch address |
| data_req | input | 1 | Request an external data access |
| data_wr | input | 1 | 1 = write, 0 = read |
| data_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| data_addr | input | 16 | Data access address |
| data_wdata | input | 8 | Write data |
| hi_reg | input | 8 | Value for the high port when no high address byte applies |
| ad_in | input | 8 | Value read back from the low port pads |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| hi_port | output | 8 | High port value |
| ad_out | output | 8 | Low address/data port value |
| ad_oe | output | 1 | Low port active drive enable |
| data_taken | output | 1 | One-clock pulse: request accepted |
| rdata | output | 8 | Last captured read byte |
| rdata_valid | output | 1 | One-clock pulse: `rdata` updated |
| rdata_is_code | output | 1 | Captured byte came from a code fetch |

## Verification
The assertions take for granted that `osc_en` is a single-clock pulse, so that position changes and capture pulses stay one clock wide. They also take for granted that request fields are stable on the tick that samples them. The bench raises `osc_en` for exactly one clock with a low clock between ticks. It sets `data_req`, the data fields and `code_ext` at position 0 of a first half, and changes them only after `data_taken` has been seen or after a whole machine cycle. With that stimulus the strobe exclusivity and drive-enable rules are always in force.

// File: rtl/xbus_seq_pkg.sv
// Package: shared types for the external bus sequencer.
// Assumes nothing beyond a standard SystemVerilog elaboration.
package xbus_seq_pkg;

    // Role of the current half machine cycle
    typedef enum logic [1:0] {
        HALF_FETCH = 2'd0,   // opcode fetch half
        HALF_DADDR = 2'd1,   // data address half
        HALF_DXFER = 2'd2    // data transfer half
    } half_kind_t;

endpackage

// File: rtl/xbus_slot_timer.sv
// Module: xbus_slot_timer
// Counts oscillator ticks within a half machine cycle and toggles the half flag.
// Assumes osc_en is high for one clock per oscillator period.
module xbus_slot_timer #(
    parameter int PHASES_PER_STATE = 2,
    parameter int STATES_PER_MC    = 6,
    localparam int HALF_SLOTS      = (PHASES_PER_STATE * STATES_PER_MC) / 2,
    localparam int LOC_W           = $clog2(HALF_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    output logic [LOC_W-1:0] loc,
    output logic             second_half,
    output logic             half_last
);

    localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(HALF_SLOTS - 1);

    // Advance the position on each tick, wrapping into the other half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc         <= '0;
            second_half <= 1'b0;
        end else if (osc_en) begin
            if (loc == LAST_LOC) begin
                loc         <= '0;
                second_half <= ~second_half;
            end else begin
                loc <= loc + 1'b1;
            end
        end
    end

    // Flag the final position of a half
    always_comb begin
        half_last = (loc == LAST_LOC);
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> ($stable(loc) && $stable(second_half)));  // R1
    AST_LOC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        loc <= LAST_LOC);  // R1

endmodule

// File: rtl/xbus_half_sched.sv
// Module: xbus_half_sched
// Chooses the role of each half machine cycle and latches fetch and data fields.
// Assumes request fields are stable on the tick that closes a first half.
module xbus_half_sched
    import xbus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              half_last,
    input  logic              second_half,
    input  logic              code_ext,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic              data_req,
    input  logic              data_wr,
    input  logic              data_wide,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    output half_kind_t        kind,
    output logic              fetch_ext,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              dacc_wr,
    output logic              dacc_wide,
    output logic [ADDR_W-1:0] dacc_addr,
    output logic [DATA_W-1:0] dacc_wdata,
    output logic              data_taken
);

    logic half_end;
    logic accept;

    // Decode the half boundary and whether a data request is taken there
    always_comb begin
        half_end = osc_en && half_last;
        accept   = half_end && (kind != HALF_DADDR) && !second_half && data_req;
    end

    // Select the next half role and capture the fields it uses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind       <= HALF_FETCH;
            fetch_ext  <= 1'b0;
            fetch_addr <= '0;
            dacc_wr    <= 1'b0;
            dacc_wide  <= 1'b0;
            dacc_addr  <= '0;
            dacc_wdata <= '0;
            data_taken <= 1'b0;
        end else begin
            data_taken <= accept;
            if (half_end) begin
                if (kind == HALF_DADDR) begin
                    kind <= HALF_DXFER;
                end else if (accept) begin
                    kind       <= HALF_DADDR;
                    dacc_wr    <= data_wr;
                    dacc_wide  <= data_wide;
                    dacc_addr  <= data_addr;
                    dacc_wdata <= data_wdata;
                end else begin
                    kind       <= HALF_FETCH;
                    fetch_ext  <= code_ext;
                    fetch_addr <= pc_addr;
                end
            end
        end
    end

    AST_XFER_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == HALF_DADDR && half_end) |=> kind == HALF_DXFER);  // R4
    AST_ADDR_IN_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == HALF_DADDR) |-> second_half);  // R4

endmodule

// File: rtl/xbus_strobe_dec.sv
// Module: xbus_strobe_dec
// Decodes the four bus strobes from the half role and the position in the half.
// Assumes ALE_POS + PHASES_PER_STATE <= STB_POS < half length.
module xbus_strobe_dec
    import xbus_seq_pkg::*;
#(
    parameter int PHASES_PER_STATE = 2,
    parameter int LOC_W            = 3,
    parameter int ALE_POS          = 2,
    parameter int STB_POS          = 4
) (
    input  half_kind_t       kind,
    input  logic             fetch_ext,
    input  logic             dacc_wr,
    input  logic [LOC_W-1:0] loc,
    output logic             ale,
    output logic             psen_n,
    output logic             rd_n,
    output logic             wr_n
);

    localparam logic [LOC_W-1:0] ALE_LO = LOC_W'(ALE_POS);
    localparam logic [LOC_W-1:0] ALE_HI = LOC_W'(ALE_POS + PHASES_PER_STATE);
    localparam logic [LOC_W-1:0] STB_LO = LOC_W'(STB_POS);

    // Produce latch and read/write strobes for the current position
    always_comb begin
        ale    = (kind != HALF_DXFER) && (loc >= ALE_LO) && (loc < ALE_HI);
        psen_n = !((kind == HALF_FETCH) && fetch_ext && (loc >= STB_LO));
        rd_n   = !((kind == HALF_DXFER) && !dacc_wr);
        wr_n   = !((kind == HALF_DXFER) && dacc_wr);
    end

endmodule

// File: rtl/xbus_port_mux.sv
// Module: xbus_port_mux
// Drives the high port and the shared low port, and captures read data.
// Assumes the strobe decoder uses the same STB_POS for its read window.
module xbus_port_mux
    import xbus_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int LOC_W   = 3,
    parameter int STB_POS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  half_kind_t        kind,
    input  logic [LOC_W-1:0]  loc,
    input  logic              half_last,
    input  logic              fetch_ext,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              dacc_wr,
    input  logic              dacc_wide,
    input  logic [ADDR_W-1:0] dacc_addr,
    input  logic [DATA_W-1:0] dacc_wdata,
    input  logic [DATA_W-1:0] hi_reg,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] hi_port,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              rdata_is_code
);

    localparam logic [LOC_W-1:0] STB_LO = LOC_W'(STB_POS);

    logic addr_phase;
    logic capture;
    logic [DATA_W-1:0] data_hi;

    // Route address bytes, write data or the float value onto the ports
    always_comb begin
        addr_phase = (loc < STB_LO);
        data_hi    = dacc_wide ? dacc_addr[ADDR_W-1 -: DATA_W] : hi_reg;
        hi_port    = hi_reg;
        ad_out     = '1;
        ad_oe      = 1'b0;
        case (kind)
            HALF_FETCH: begin
                if (fetch_ext) begin
                    hi_port = fetch_addr[ADDR_W-1 -: DATA_W];
                    if (addr_phase) begin
                        ad_out = fetch_addr[DATA_W-1:0];
                        ad_oe  = 1'b1;
                    end
                end
            end
            HALF_DADDR: begin
                hi_port = data_hi;
                if (addr_phase) begin
                    ad_out = dacc_addr[DATA_W-1:0];
                    ad_oe  = 1'b1;
                end else if (dacc_wr) begin
                    ad_out = dacc_wdata;
                    ad_oe  = 1'b1;
                end
            end
            HALF_DXFER: begin
                hi_port = data_hi;
                if (dacc_wr) begin
                    ad_out = dacc_wdata;
                    ad_oe  = 1'b1;
                end
            end
            default: begin
                hi_port = hi_reg;
            end
        endcase
        capture = osc_en && half_last &&
                  (((kind == HALF_FETCH) && fetch_ext) ||
                   ((kind == HALF_DXFER) && !dacc_wr));
    end

    // Sample the pad value on the last phase of a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata         <= '0;
            rdata_valid   <= 1'b0;
            rdata_is_code <= 1'b0;
        end else begin
            rdata_valid <= capture;
            if (capture) begin
                rdata         <= ad_in;
                rdata_is_code <= (kind == HALF_FETCH);
            end
        end
    end

    AST_FLOAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |-> (ad_out == '1));  // R12
    AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);  // R9

endmodule

// File: rtl/xbus_seq.sv
// Module: xbus_seq (top)
// Sequences a multiplexed address/data external bus: latch strobe, program-store
// and data strobes, high and low ports. Assumes osc_en is a one-clock pulse.
module xbus_seq
    import xbus_seq_pkg::*;
#(
    parameter int ADDR_W           = 16,
    parameter int DATA_W           = 8,
    parameter int PHASES_PER_STATE = 2,
    parameter int STATES_PER_MC    = 6,
    parameter int ALE_POS          = 2,
    parameter int STB_POS          = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              code_ext,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic              data_req,
    input  logic              data_wr,
    input  logic              data_wide,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic [DATA_W-1:0] hi_reg,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] hi_port,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              data_taken,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              rdata_is_code
);

    localparam int HALF_SLOTS = (PHASES_PER_STATE * STATES_PER_MC) / 2;
    localparam int LOC_W      = $clog2(HALF_SLOTS);

    logic [LOC_W-1:0]  loc;
    logic              second_half;
    logic              half_last;
    half_kind_t        kind;
    logic              fetch_ext;
    logic [ADDR_W-1:0] fetch_addr;
    logic              dacc_wr;
    logic              dacc_wide;
    logic [ADDR_W-1:0] dacc_addr;
    logic [DATA_W-1:0] dacc_wdata;

    xbus_slot_timer #(
        .PHASES_PER_STATE(PHASES_PER_STATE),
        .STATES_PER_MC   (STATES_PER_MC)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_en     (osc_en),
        .loc        (loc),
        .second_half(second_half),
        .half_last  (half_last)
    );

    xbus_half_sched #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) sched_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_en     (osc_en),
        .half_last  (half_last),
        .second_half(second_half),
        .code_ext   (code_ext),
        .pc_addr    (pc_addr),
        .data_req   (data_req),
        .data_wr    (data_wr),
        .data_wide  (data_wide),
        .data_addr  (data_addr),
        .data_wdata (data_wdata),
        .kind       (kind),
        .fetch_ext  (fetch_ext),
        .fetch_addr (fetch_addr),
        .dacc_wr    (dacc_wr),
        .dacc_wide  (dacc_wide),
        .dacc_addr  (dacc_addr),
        .dacc_wdata (dacc_wdata),
        .data_taken (data_taken)
    );

    xbus_strobe_dec #(
        .PHASES_PER_STATE(PHASES_PER_STATE),
        .LOC_W           (LOC_W),
        .ALE_POS         (ALE_POS),
        .STB_POS         (STB_POS)
    ) strobe_i (
        .kind     (kind),
        .fetch_ext(fetch_ext),
        .dacc_wr  (dacc_wr),
        .loc      (loc),
        .ale      (ale),
        .psen_n   (psen_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n)
    );

    xbus_port_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LOC_W  (LOC_W),
        .STB_POS(STB_POS)
    ) port_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_en       (osc_en),
        .kind         (kind),
        .loc          (loc),
        .half_last    (half_last),
        .fetch_ext    (fetch_ext),
        .fetch_addr   (fetch_addr),
        .dacc_wr      (dacc_wr),
        .dacc_wide    (dacc_wide),
        .dacc_addr    (dacc_addr),
        .dacc_wdata   (dacc_wdata),
        .hi_reg       (hi_reg),
        .ad_in        (ad_in),
        .hi_port      (hi_port),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .rdata        (rdata),
        .rdata_valid  (rdata_valid),
        .rdata_is_code(rdata_is_code)
    );

    AST_LATCH_NOT_WITH_PSEN: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> psen_n);  // R3
    AST_NO_LATCH_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (!ale && psen_n));  // R5
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> wr_n);  // R10
    AST_FLOAT_WHILE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !ad_oe);  // R9
    AST_DRIVE_WHILE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);  // R10

endmodule

// File: tb/xbus_seq_tb_top.sv
// Directed bench for xbus_seq: one task per scenario, each checking its results.
module xbus_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MC_TICKS   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b0;
    logic        code_ext = 1'b0;
    logic [15:0] pc_addr = '0;
    logic        data_req = 1'b0;
    logic        data_wr = 1'b0;
    logic        data_wide = 1'b0;
    logic [15:0] data_addr = '0;
    logic [7:0]  data_wdata = '0;
    logic [7:0]  hi_reg = 8'h77;
    logic [7:0]  ad_in = '0;
    logic        ale, psen_n, rd_n, wr_n, ad_oe, data_taken, rdata_valid, rdata_is_code;
    logic [7:0]  hi_port, ad_out, rdata;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  tb_slot = 0;
    int  cnt_ale, cnt_psen, cnt_rd, cnt_wr;
    logic prev_ale, prev_psen_n, prev_rd_n, prev_wr_n;
    logic seen_taken, seen_valid, seen_code;
    logic [7:0] seen_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xbus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .code_ext(code_ext),
        .pc_addr(pc_addr), .data_req(data_req), .data_wr(data_wr),
        .data_wide(data_wide), .data_addr(data_addr), .data_wdata(data_wdata),
        .hi_reg(hi_reg), .ad_in(ad_in), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .hi_port(hi_port), .ad_out(ad_out),
        .ad_oe(ad_oe), .data_taken(data_taken), .rdata(rdata),
        .rdata_valid(rdata_valid), .rdata_is_code(rdata_is_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        cnt_ale = 0; cnt_psen = 0; cnt_rd = 0; cnt_wr = 0;
        prev_ale = ale; prev_psen_n = psen_n; prev_rd_n = rd_n; prev_wr_n = wr_n;
    endtask

    // One oscillator tick, then sample away from the edge and count strobe starts
    task automatic tick();
        @(negedge clk) osc_en = 1'b1;
        @(negedge clk) osc_en = 1'b0;
        seen_taken = data_taken;
        seen_valid = rdata_valid;
        seen_rdata = rdata;
        seen_code  = rdata_is_code;
        tb_slot = (tb_slot + 1) % MC_TICKS;
        if (ale && !prev_ale) cnt_ale++;
        if (!psen_n && prev_psen_n) cnt_psen++;
        if (!rd_n && prev_rd_n) cnt_rd++;
        if (!wr_n && prev_wr_n) cnt_wr++;
        prev_ale = ale; prev_psen_n = psen_n; prev_rd_n = rd_n; prev_wr_n = wr_n;
    endtask

    task automatic advance_to(input int target);
        do tick(); while (tb_slot != target);
    endtask

    task automatic test_reset_and_hold();
        chk("R11 ale", ale, 0);
        chk("R11 psen_n", psen_n, 1);
        chk("R11 rd_n/wr_n", {rd_n, wr_n}, 2'b11);
        chk("R11 ad_oe", ad_oe, 0);
        chk("R11 ad_out", ad_out, 8'hFF);
        clear_counts();
        advance_to(2);
        chk("R2 ale at position 2", ale, 1);
        repeat (6) @(negedge clk);
        chk("R1 no tick keeps ale", ale, 1);
        tick();
        chk("R1 ale at position 3", ale, 1);
        tick();
        chk("R1 ale drops at position 4", ale, 0);
    endtask

    task automatic test_ext_fetch();
        code_ext = 1'b1; pc_addr = 16'h12A5;
        advance_to(0);
        clear_counts();
        advance_to(2);
        chk("R7 fetch addr low", ad_out, 8'hA5);
        chk("R7 fetch oe", ad_oe, 1);
        chk("R8 fetch hi byte", hi_port, 8'h12);
        advance_to(4);
        chk("R3 psen low", psen_n, 0);
        chk("R9 oe off under psen", ad_oe, 0);
        ad_in = 8'h3C;
        advance_to(6);
        chk("R9 code capture valid", seen_valid, 1);
        chk("R9 code capture data", seen_rdata, 8'h3C);
        chk("R9 code capture kind", seen_code, 1);
        pc_addr = 16'h34FF;
        advance_to(0);
        chk("R2 ext fetch ale count", cnt_ale, 2);
        chk("R3 ext fetch psen count", cnt_psen, 2);
        advance_to(2);
        chk("R7 strong ones driven", {ad_oe, ad_out}, 9'h1FF);
        chk("R8 new hi byte", hi_port, 8'h34);
    endtask

    task automatic test_int_fetch();
        advance_to(0);
        code_ext = 1'b0; hi_reg = 8'h77;
        advance_to(0);
        clear_counts();
        advance_to(2);
        chk("R12 internal float", {ad_oe, ad_out}, 9'h0FF);
        chk("R8 internal hi_reg", hi_port, 8'h77);
        advance_to(0);
        chk("R2 int fetch ale count", cnt_ale, 2);
        chk("R3 int fetch psen count", cnt_psen, 0);
    endtask

    task automatic data_access(input string nm, input bit ext, input bit wr, input bit wide,
                               input logic [15:0] addr, input logic [7:0] wd, input logic [7:0] rd);
        code_ext = ext;
        advance_to(0);
        hi_reg = 8'h5A;
        data_req = 1'b1; data_wr = wr; data_wide = wide; data_addr = addr; data_wdata = wd;
        clear_counts();
        advance_to(6);
        chk({"R4 taken ", nm}, seen_taken, 1);
        data_req = 1'b0; data_addr = 16'h0000; data_wdata = 8'h00;
        advance_to(8);
        chk({"R2 ale in addr half ", nm}, ale, 1);
        chk({"R7 data addr low ", nm}, {ad_oe, ad_out}, {1'b1, addr[7:0]});
        chk({"R8 data hi ", nm}, hi_port, wide ? addr[15:8] : 8'h5A);
        advance_to(10);
        chk({"R6 no psen in addr half ", nm}, psen_n, 1);
        if (wr) chk({"R10 write data early ", nm}, {ad_oe, ad_out}, {1'b1, wd});
        advance_to(2);
        chk({"R5 no ale in xfer ", nm}, ale, 0);
        if (wr) begin
            chk({"R10 wr strobe ", nm}, {wr_n, rd_n}, 2'b01);
            chk({"R10 write data ", nm}, {ad_oe, ad_out}, {1'b1, wd});
        end else begin
            chk({"R9 rd strobe ", nm}, {rd_n, wr_n}, 2'b01);
            chk({"R9 float in read ", nm}, ad_oe, 0);
            ad_in = rd;
        end
        advance_to(6);
        if (!wr) begin
            chk({"R9 read valid ", nm}, seen_valid, 1);
            chk({"R9 read data ", nm}, seen_rdata, rd);
            chk({"R9 read kind ", nm}, seen_code, 0);
        end
        chk({"R9 strobes released ", nm}, {rd_n, wr_n}, 2'b11);
        advance_to(0);
        chk({"R5 ale count ", nm}, cnt_ale, 3);
        chk({"R6 psen count ", nm}, cnt_psen, ext ? 2 : 0);
        chk({"R9 rd count ", nm}, cnt_rd, wr ? 0 : 1);
        chk({"R10 wr count ", nm}, cnt_wr, wr ? 1 : 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset_and_hold();
        test_ext_fetch();
        test_int_fetch();
        data_access("read8", 1'b1, 1'b0, 1'b0, 16'hBE47, 8'h00, 8'hC3);
        data_access("write16", 1'b1, 1'b1, 1'b1, 16'h9A10, 8'h6E, 8'h00);
        data_access("read16int", 1'b0, 1'b0, 1'b1, 16'hD2F0, 8'h00, 8'h81);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule